// File: doc/BRIEF.md
# Adaptive Settling Filter for Decimated Samples

This block is the second filtering stage behind a sinc3 decimator. It accepts one signed word each time the first stage produces a result. In its usual state it smooths that stream with a 16-tap symmetric low-pass FIR. When a new word differs from the last emitted result by more than a programmable threshold, the block assumes the input has stepped. It then emits a running mean instead. That mean is taken over a window that doubles as words arrive after the step, so the output tracks the new level within a few samples. After a fixed number of words the block returns to the FIR on its own.

A bypass input skips all filtering, and the output is then the incoming word unchanged. The tap history keeps shifting in every state, so the FIR always has real data when it resumes. Every output carries a code for the path that produced it and a flag marking results produced before the history has been filled once after reset.

Top module: `settle_filt`

## Requirements
- R1: While `rst_n` is low and right after its release, `out_valid` is 0, `out_data` is 0, `out_mode` is 0 (FIR) and `out_settling` is 0, and all 16 history entries read as zero.
- R2: Each cycle with `in_valid` high produces exactly one cycle of `out_valid` on the next clock edge, and a cycle with `in_valid` low produces none.
- R3: In FIR state (`out_mode` = 0) the output is floor((sum over k = 0..15 of c[k]·x[n−k] + 64) / 128). Here x[n] is the current word and the weights c[0..7] = 1, 2, 4, 6, 9, 12, 14, 16 are mirrored so that c[15−k] = c[k].
- R4: When bypass is low and |x[n] − previous output| is strictly greater than the unsigned `step_thr`, the result has `out_mode` = 1 (averaging) and a window of one word, so `out_data` equals x[n].
- R5: In averaging state, the k-th word since the step (k = 1 for the step word) is averaged over L words. L is the largest power of two not above k, capped at 16. The result is floor(sum of x[n]..x[n−L+1] / L), computed by an arithmetic right shift.
- R6: A step detected while averaging restarts the count at k = 1.
- R7: After 32 averaged words with no new step, the next word is filtered by the FIR and `out_mode` returns to 0.
- R8: With `bypass` high on a valid word, `out_data` equals that word and `out_mode` = 2. The history still shifts, and leaving bypass resumes in FIR state.
- R9: `out_settling` is 1 on the first 15 outputs after reset and 0 from the 16th output on.
- R10: Changes to `bypass` or `step_thr` on cycles with `in_valid` low have no effect: `out_data` and `out_mode` hold their values until the next valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A decimated word is present on `in_data` |
| in_data | input | 16 | Signed word from the first stage |
| bypass | input | 1 | Pass words straight through |
| step_thr | input | 16 | Unsigned step threshold |
| out_valid | output | 1 | Result present |
| out_data | output | 16 | Signed result |
| out_mode | output | 2 | 0 FIR, 1 averaging, 2 bypass |
| out_settling | output | 1 | History not yet filled since reset |

## Verification
Every result is due on the clock edge one cycle after its word is accepted. The path is the history register, combinational FIR, averaging and step logic, and then one output register. The bench drives inputs on the falling edge and compares all four outputs on the next falling edge. At that point the result for the previous word has just been registered, so each comparison lines up with exactly one accepted word or one idle cycle. A behavioural model tracks the history, step count and previous result, and it predicts the expected values in the same cycle as the drive. On idle cycles the bench checks that the previous values still hold.

// File: rtl/settle_filt_pkg.sv
package settle_filt_pkg;

  localparam int TAPS    = 16;
  localparam int HALF    = TAPS / 2;
  localparam int COEF_W  = 6;
  localparam int COEF_SH = 7;
  localparam int AVG_LG  = $clog2(TAPS);

  typedef enum logic [1:0] {
    MODE_FIR = 2'd0,
    MODE_AVG = 2'd1,
    MODE_BYP = 2'd2
  } mode_e;

  // Mirrored low-pass weights, total 128 for unity gain at DC.
  function automatic logic signed [COEF_W-1:0] fir_weight(input int idx);
    int m;
    m = (idx < HALF) ? idx : (TAPS - 1 - idx);
    case (m)
      0:       return 6'sd1;
      1:       return 6'sd2;
      2:       return 6'sd4;
      3:       return 6'sd6;
      4:       return 6'sd9;
      5:       return 6'sd12;
      6:       return 6'sd14;
      7:       return 6'sd16;
      default: return 6'sd0;
    endcase
  endfunction

endpackage

// File: rtl/settle_delay_line.sv
module settle_delay_line #(
  parameter int DW   = 16,
  parameter int TAPS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic [DW-1:0]            din,
  output logic [TAPS-1:0][DW-1:0]  win_o,
  output logic                     full_o
);
  localparam int FW = $clog2(TAPS + 1);

  logic [TAPS-1:0][DW-1:0] line_q, line_d;
  logic [FW-1:0]           fill_q, fill_d;

  // Window as it will look once this word is shifted in.
  always_comb begin
    line_d[0] = din;
    for (int i = 1; i < TAPS; i++) line_d[i] = line_q[i-1];
    fill_d = (fill_q == FW'(TAPS)) ? fill_q : fill_q + FW'(1);
  end

  assign win_o  = line_d;
  assign full_o = (fill_d == FW'(TAPS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      fill_q <= '0;
    end else if (shift_en) begin
      line_q <= line_d;
      fill_q <= fill_d;
    end
  end

  p_fill_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FW'(TAPS));

  p_fill_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(fill_q));

endmodule

// File: rtl/settle_fir.sv
module settle_fir
  import settle_filt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [TAPS-1:0][DW-1:0] win_i,
  output logic [DW+COEF_W+4:0]    acc_rnd_o
);
  localparam int ACC_W = DW + COEF_W + 5;

  logic signed [ACC_W-1:0] prod [HALF];

  // Symmetric pairs are added first, then weighted once per pair.
  for (genvar g = 0; g < HALF; g++) begin : g_pair
    logic signed [ACC_W-1:0] pre;
    logic signed [ACC_W-1:0] wt;
    assign pre     = ACC_W'($signed(win_i[g])) + ACC_W'($signed(win_i[TAPS-1-g]));
    assign wt      = ACC_W'(fir_weight(g));
    assign prod[g] = pre * wt;
  end

  logic signed [ACC_W-1:0] acc;
  always_comb begin
    acc = '0;
    for (int i = 0; i < HALF; i++) acc = acc + prod[i];
  end

  logic signed [ACC_W-1:0] rnd;
  assign rnd       = (acc + ACC_W'(1 << (COEF_SH - 1))) >>> COEF_SH;
  assign acc_rnd_o = rnd;

endmodule

// File: rtl/settle_avg.sv
module settle_avg
  import settle_filt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [TAPS-1:0][DW-1:0] win_i,
  input  logic [2:0]              lg_i,
  output logic [DW-1:0]           avg_o
);
  localparam int SW = DW + AVG_LG + 1;

  logic signed [SW-1:0] psum [TAPS];

  // Running prefix sums: psum[i] covers the newest i+1 words.
  assign psum[0] = SW'($signed(win_i[0]));
  for (genvar g = 1; g < TAPS; g++) begin : g_prefix
    assign psum[g] = psum[g-1] + SW'($signed(win_i[g]));
  end

  logic signed [SW-1:0] picked;
  logic signed [SW-1:0] shifted;
  always_comb begin
    int sel;
    sel = (1 << int'(lg_i)) - 1;
    if (sel > TAPS - 1) sel = TAPS - 1;
    picked  = psum[sel];
    shifted = picked >>> lg_i;
  end

  assign avg_o = shifted[DW-1:0];

endmodule

// File: rtl/settle_ctrl.sv
module settle_ctrl
  import settle_filt_pkg::*;
#(
  parameter int AVG_SPAN = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       bypass,
  input  logic       step_hit,
  output mode_e      mode_n_o,
  output logic [2:0] lg_o
);
  localparam int CW = $clog2(AVG_SPAN + 1);

  mode_e         mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    lg_d;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (bypass) begin
      mode_d = MODE_BYP;
      cnt_d  = '0;
    end else if (step_hit) begin
      mode_d = MODE_AVG;
      cnt_d  = CW'(1);
    end else if (mode_q == MODE_AVG) begin
      if (cnt_q == CW'(AVG_SPAN)) begin
        mode_d = MODE_FIR;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + CW'(1);
      end
    end else begin
      mode_d = MODE_FIR;
      cnt_d  = '0;
    end
  end

  // Window length: largest power of two not above the count.
  always_comb begin
    lg_d = 3'd0;
    for (int b = 1; b <= AVG_LG; b++) begin
      if (int'(cnt_d) >= (1 << b)) lg_d = 3'(b);
    end
  end

  assign mode_n_o = mode_d;
  assign lg_o     = lg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FIR;
      cnt_q  <= '0;
    end else if (in_valid) begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  p_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_AVG) |-> (cnt_q >= CW'(1) && cnt_q <= CW'(AVG_SPAN)));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bypass && step_hit) |=> (mode_q == MODE_AVG && cnt_q == CW'(1)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(mode_q) && $stable(cnt_q)));

endmodule

// File: rtl/settle_filt.sv
module settle_filt
  import settle_filt_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AVG_SPAN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          bypass,
  input  logic [DW-1:0] step_thr,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [1:0]    out_mode,
  output logic          out_settling
);
  localparam int ACC_W = DW + COEF_W + 5;

  logic [TAPS-1:0][DW-1:0] win;
  logic                    full;
  logic [ACC_W-1:0]        fir_wide;
  logic [DW-1:0]           fir_y;
  logic [DW-1:0]           avg_y;
  logic [2:0]              lg;
  mode_e                   mode_n;
  logic                    step_hit;

  logic                    vld_q;
  logic [DW-1:0]           data_q, data_d;
  mode_e                   mode_q;
  logic                    settle_q;

  settle_delay_line #(.DW(DW), .TAPS(TAPS)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (in_valid),
    .din      (in_data),
    .win_o    (win),
    .full_o   (full)
  );

  settle_fir #(.DW(DW)) u_fir (
    .win_i     (win),
    .acc_rnd_o (fir_wide)
  );
  assign fir_y = fir_wide[DW-1:0];

  settle_avg #(.DW(DW)) u_avg (
    .win_i (win),
    .lg_i  (lg),
    .avg_o (avg_y)
  );

  // Step test against the last emitted result.
  logic signed [DW:0] diff;
  logic        [DW:0] mag;
  assign diff     = (DW+1)'($signed(in_data)) - (DW+1)'($signed(data_q));
  assign mag      = diff[DW] ? (~diff + (DW+1)'(1)) : diff;
  assign step_hit = !bypass && (mag > {1'b0, step_thr});

  settle_ctrl #(.AVG_SPAN(AVG_SPAN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .bypass   (bypass),
    .step_hit (step_hit),
    .mode_n_o (mode_n),
    .lg_o     (lg)
  );

  always_comb begin
    case (mode_n)
      MODE_BYP: data_d = in_data;
      MODE_AVG: data_d = avg_y;
      default:  data_d = fir_y;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      mode_q   <= MODE_FIR;
      settle_q <= 1'b0;
    end else if (in_valid) begin
      data_q   <= data_d;
      mode_q   <= mode_n;
      settle_q <= !full;
    end
  end

  assign out_valid    = vld_q;
  assign out_data     = data_q;
  assign out_mode     = mode_q;
  assign out_settling = settle_q;

  p_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_mode)));

  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bypass) |=> (out_data == $past(in_data) && out_mode == MODE_BYP));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && step_hit) |=> (out_mode == MODE_AVG && out_data == $past(in_data)));

  p_fir_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((&fir_wide[ACC_W-1:DW-1]) || !(|fir_wide[ACC_W-1:DW-1])));

endmodule

// File: tb/settle_filt_tb.sv
module settle_filt_tb;

  localparam int N    = 16;
  localparam int SPAN = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        bypass;
  logic [15:0] step_thr;
  logic        out_valid;
  logic [15:0] out_data;
  logic [1:0]  out_mode;
  logic        out_settling;

  always #4 clk = ~clk;

  settle_filt u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .bypass       (bypass),
    .step_thr     (step_thr),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_mode     (out_mode),
    .out_settling (out_settling)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // Reference state
  int hist[N];
  int fill = 0;
  int last = 0;
  int mdl_mode = 0;
  int k = 0;
  int exp_data = 0;
  int exp_mode = 0;
  bit exp_settle = 0;
  string tag = "R3";
  int wts[8] = '{1, 2, 4, 6, 9, 12, 14, 16};

  function automatic int weight(int i);
    return (i < 8) ? wts[i] : wts[N-1-i];
  endfunction

  task automatic check(bit ok, string rq, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  task automatic model(int x, bit byp);
    int acc, len, lgv, s, prev;
    for (int i = N-1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    if (fill < N) fill++;
    acc = 0;
    for (int i = 0; i < N; i++) acc += weight(i) * hist[i];
    acc = (acc + 64) >>> 7;
    prev = mdl_mode;
    s = x - last;
    if (s < 0) s = -s;
    if (byp) begin
      mdl_mode = 2; k = 0; exp_data = x; tag = "R8";
    end else if (s > int'(step_thr)) begin
      tag = (prev == 1) ? "R6" : "R4";
      mdl_mode = 1; k = 1;
    end else if (prev == 1) begin
      if (k == SPAN) begin
        mdl_mode = 0; k = 0; tag = "R7";
      end else begin
        k++; tag = "R5";
      end
    end else begin
      mdl_mode = 0; k = 0; tag = "R3";
    end
    if (mdl_mode == 1) begin
      len = 1; lgv = 0;
      while (len * 2 <= k && len < N) begin len *= 2; lgv++; end
      s = 0;
      for (int i = 0; i < len; i++) s += hist[i];
      exp_data = s >>> lgv;
    end else if (mdl_mode == 0) begin
      exp_data = acc;
    end
    last = exp_data;
    exp_mode = mdl_mode;
    exp_settle = (fill < N);
  endtask

  // Drive on the falling edge, compare on the next falling edge.
  task automatic cyc(bit v, int d, bit b);
    in_valid = v;
    in_data  = 16'(d);
    bypass   = b;
    if (v) model(d, b);
    @(negedge clk);
    check(out_valid == v, "R2", "out_valid", int'(out_valid), int'(v));
    if (v) begin
      check(int'($signed(out_data)) == exp_data, tag, "out_data", int'($signed(out_data)), exp_data);
      check(int'(out_mode) == exp_mode, tag, "out_mode", int'(out_mode), exp_mode);
      check(out_settling == exp_settle, "R9", "out_settling", int'(out_settling), int'(exp_settle));
    end else begin
      check(int'($signed(out_data)) == last, "R10", "held out_data", int'($signed(out_data)), last);
      check(int'(out_mode) == exp_mode, "R10", "held out_mode", int'(out_mode), exp_mode);
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) hist[i] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; bypass = 1'b0; step_thr = 16'd1000;
    repeat (3) @(negedge clk);
    // R1: outputs at reset
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(out_data == 16'd0, "R1", "out_data in reset", int'(out_data), 0);
    check(out_mode == 2'd0, "R1", "out_mode in reset", int'(out_mode), 0);
    check(out_settling == 1'b0, "R1", "out_settling in reset", int'(out_settling), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after release", int'(out_valid), 0);

    // Slow ramp, FIR with settling flag, idle gaps
    for (int i = 0; i < 24; i++) begin
      cyc(1'b1, i * 20, 1'b0);
      if (i % 5 == 4) cyc(1'b0, 0, 1'b0);
    end
    // Large step up: averaging, then back to FIR
    for (int i = 0; i < 40; i++) cyc(1'b1, 20000 + (i % 3), 1'b0);
    // Step down, restart mid-average
    for (int i = 0; i < 5; i++) cyc(1'b1, -15000, 1'b0);
    for (int i = 0; i < 40; i++) begin
      cyc(1'b1, -5000 - (i % 4), 1'b0);
      if (i == 10) cyc(1'b0, 0, 1'b0);
    end
    // Bypass with control toggles on idle cycles
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1, 1234 * i - 3000, 1'b1);
      cyc(1'b0, 999, 1'b0);
      step_thr = 16'd0;
      cyc(1'b0, 999, 1'b1);
      step_thr = 16'd1000;
    end
    // Leave bypass, then extremes with the threshold out of reach
    step_thr = 16'hFFFF;
    for (int i = 0; i < 20; i++) cyc(1'b1, (i % 2) ? -32768 : 32767, 1'b0);
    for (int i = 0; i < 18; i++) cyc(1'b1, 32767, 1'b0);
    // Zero threshold: any change is a step
    step_thr = 16'd0;
    for (int i = 0; i < 6; i++) cyc(1'b1, 100 + i, 1'b0);
    for (int i = 0; i < 4; i++) cyc(1'b1, 105, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule